// File: doc/BRIEF.md
# Note Command Parser for a MIDI Byte Stream

This block sits behind a serial receiver and watches the bytes it delivers. A byte is taken on each clock in which the ready strobe is high. From these bytes the parser picks out note-on and note-off messages. Every other message is consumed and dropped without producing any output.

For each complete note message the block raises a one-cycle pulse on one of two outputs, one for note-on and one for note-off. In the same cycle it loads the message's key number and velocity into two registers. These registers hold their values until the next recognized message. Running status is supported, so repeated key/velocity pairs after a single status byte each count as a further command. A note-on whose velocity is zero is reported as a note-off. The controller is a small state machine with one-hot state encoding.

Top module: `note_parser`

## Requirements
- R1: A byte is consumed only in a cycle where `rx_valid` is high. Bus values presented while `rx_valid` is low have no effect on the outputs or on the message in progress.
- R2: A byte with bit 7 set is a status byte, and a byte with bit 7 clear is a data byte. A status byte whose upper nibble is 0x9 selects note-on and one whose upper nibble is 0x8 selects note-off. The channel in the lower nibble does not matter.
- R3: After a note-on status, a key byte and a nonzero velocity byte cause `note_on` to be high for exactly the one cycle following the clock edge that takes the velocity byte. `note_on` and `note_off` are never high together.
- R4: After a note-off status, a key byte and a velocity byte of any value cause `note_off` to be high for exactly one cycle, with the same timing as R3.
- R5: Under a note-on status, a velocity byte of zero produces a `note_off` pulse and no `note_on` pulse.
- R6: `key_out` and `vel_out` take the 7-bit key and velocity of a completed command in the same cycle as its pulse. They hold their values in every other cycle.
- R7: After a note status byte, each further key/velocity data pair that arrives without a new status byte is a further command of the same type.
- R8: Bytes 0xF8 through 0xFF are ignored wherever they arrive, including between the bytes of a message. The message in progress carries on unchanged.
- R9: Any other status byte (0xA0–0xF7) starts a discard mode. In this mode data bytes are dropped until the next note status byte arrives.
- R10: A status byte that arrives before a message is complete abandons the partial message without any pulse.
- R11: After reset both pulses are low, `key_out` and `vel_out` are zero, and data bytes that arrive before the first note status byte are dropped.
- R12: Exactly one state bit of the controller is set at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| rx_data | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | One-cycle strobe, high when `rx_data` holds a new byte |
| note_on | output | 1 | One-cycle pulse for a recognized note-on |
| note_off | output | 1 | One-cycle pulse for a recognized note-off (either encoding) |
| key_out | output | 7 | Key number of the last recognized command |
| vel_out | output | 7 | Velocity of the last recognized command |

## Verification
The checker assumes that `rx_valid` is a clean strobe with `rx_data` stable at the sampling edge. It also assumes that whole messages need at least two strobes, so two completions can never fall in back-to-back cycles. The bench drives every byte on the falling edge and holds `rx_valid` high for a single cycle. Random traffic mixes note status bytes on all channels, real-time bytes, other status bytes and data bytes, some with zero velocity. Idle gaps with junk on the bus test that unstrobed values are ignored.

// File: rtl/note_parser_pkg.sv
package note_parser_pkg;

   localparam int unsigned NUM_ST = 4;

   // Bit positions in the one-hot state vector
   localparam int unsigned IX_IDLE = 0;  // after reset, waiting for a note status
   localparam int unsigned IX_DISC = 1;  // dropping data of a foreign message
   localparam int unsigned IX_KEY  = 2;  // expecting the key byte
   localparam int unsigned IX_VEL  = 3;  // expecting the velocity byte

   typedef struct packed {
      logic is_rt;      // real-time byte, transparent to parsing
      logic is_on_st;   // note-on status, any channel
      logic is_off_st;  // note-off status, any channel
      logic is_oth_st;  // any other status byte
      logic is_data;    // bit 7 clear
   } byte_class_t;

endpackage

// File: rtl/note_byte_classify.sv
module note_byte_classify
   import note_parser_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   output byte_class_t       cls_o
);
   localparam int unsigned NIB = 4;

   logic            status_w;
   logic [NIB-1:0]  hi_nib;
   logic            rt_w;

   assign status_w = byte_i[DATA_W-1];
   assign hi_nib   = byte_i[DATA_W-1 -: NIB];
   assign rt_w     = (byte_i[DATA_W-1 -: 5] == 5'b11111);

   always_comb begin
      cls_o           = '0;
      cls_o.is_data   = !status_w;
      cls_o.is_rt     = status_w && rt_w;
      cls_o.is_on_st  = status_w && (hi_nib == 4'h9);
      cls_o.is_off_st = status_w && (hi_nib == 4'h8);
      cls_o.is_oth_st = status_w && !rt_w && (hi_nib != 4'h9) && (hi_nib != 4'h8);
   end
endmodule

// File: rtl/note_parse_fsm.sv
module note_parse_fsm
   import note_parser_pkg::*;
#(
   parameter int unsigned N_ST = NUM_ST
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid_i,
   input  byte_class_t     cls_i,
   input  logic            zero_vel_i,
   output logic [N_ST-1:0] state_o,
   output logic            capt_key_o,
   output logic            fire_on_o,
   output logic            fire_off_o
);
   logic [N_ST-1:0] st_q;
   logic [N_ST-1:0] st_d;
   logic            run_on_q;
   logic            data_stb;

   assign data_stb = valid_i && cls_i.is_data;

   always_comb begin
      st_d = st_q;
      if (valid_i && !cls_i.is_rt) begin
         if (cls_i.is_on_st || cls_i.is_off_st) begin
            st_d         = '0;
            st_d[IX_KEY] = 1'b1;
         end else if (cls_i.is_oth_st) begin
            st_d          = '0;
            st_d[IX_DISC] = 1'b1;
         end else if (st_q[IX_KEY]) begin
            st_d         = '0;
            st_d[IX_VEL] = 1'b1;
         end else if (st_q[IX_VEL]) begin
            st_d         = '0;
            st_d[IX_KEY] = 1'b1;  // running status: next pair reuses the type
         end
      end
   end

   // One flop per state bit; only the idle bit resets to one
   for (genvar i = 0; i < N_ST; i++) begin : g_st
      always_ff @(posedge clk) begin
         if (!rst_n) st_q[i] <= (i == IX_IDLE);
         else        st_q[i] <= st_d[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          run_on_q <= 1'b0;
      else if (valid_i && cls_i.is_on_st)  run_on_q <= 1'b1;
      else if (valid_i && cls_i.is_off_st) run_on_q <= 1'b0;
   end

   assign state_o    = st_q;
   assign capt_key_o = data_stb && st_q[IX_KEY];
   assign fire_on_o  = data_stb && st_q[IX_VEL] && run_on_q && !zero_vel_i;
   assign fire_off_o = data_stb && st_q[IX_VEL] && (!run_on_q || zero_vel_i);
endmodule

// File: rtl/note_out_reg.sv
module note_out_reg #(
   parameter int unsigned VAL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] data_i,
   input  logic             capt_key_i,
   input  logic             fire_on_i,
   input  logic             fire_off_i,
   output logic             on_o,
   output logic             off_o,
   output logic [VAL_W-1:0] key_o,
   output logic [VAL_W-1:0] vel_o
);
   logic [VAL_W-1:0] pend_key_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_key_q <= '0;
         key_o      <= '0;
         vel_o      <= '0;
         on_o       <= 1'b0;
         off_o      <= 1'b0;
      end else begin
         on_o  <= fire_on_i;
         off_o <= fire_off_i;
         if (capt_key_i) pend_key_q <= data_i;
         if (fire_on_i || fire_off_i) begin
            key_o <= pend_key_q;
            vel_o <= data_i;
         end
      end
   end
endmodule

// File: rtl/note_parser.sv
module note_parser
   import note_parser_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned VAL_W = DATA_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DATA_W-1:0] rx_data,
   input  logic             rx_valid,
   output logic             note_on,
   output logic             note_off,
   output logic [VAL_W-1:0] key_out,
   output logic [VAL_W-1:0] vel_out
);
   if (DATA_W != 8) begin : g_bad_width
      $error("note_parser: DATA_W must be 8");
   end

   byte_class_t       cls;
   logic [NUM_ST-1:0] fsm_state;
   logic              capt_key;
   logic              fire_on;
   logic              fire_off;
   logic              zero_vel;

   assign zero_vel = (rx_data[VAL_W-1:0] == '0);

   note_byte_classify #(.DATA_W(DATA_W)) u_cls (
      .byte_i (rx_data),
      .cls_o  (cls)
   );

   note_parse_fsm #(.N_ST(NUM_ST)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (rx_valid),
      .cls_i      (cls),
      .zero_vel_i (zero_vel),
      .state_o    (fsm_state),
      .capt_key_o (capt_key),
      .fire_on_o  (fire_on),
      .fire_off_o (fire_off)
   );

   note_out_reg #(.VAL_W(VAL_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_i     (rx_data[VAL_W-1:0]),
      .capt_key_i (capt_key),
      .fire_on_i  (fire_on),
      .fire_off_i (fire_off),
      .on_o       (note_on),
      .off_o      (note_off),
      .key_o      (key_out),
      .vel_o      (vel_out)
   );
endmodule

// File: rtl/note_parser_chk.sv
module note_parser_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_ST   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              note_on,
   input logic              note_off,
   input logic [DATA_W-2:0] key_out,
   input logic [DATA_W-2:0] vel_out,
   input logic [N_ST-1:0]   fsm_state
);
   p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fsm_state) == 1);

   p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(note_on && note_off));

   p_on_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      note_on |=> !note_on);

   p_off_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      note_off |=> !note_off);

   p_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (note_on || note_off) |-> $past(rx_valid));

   p_on_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      note_on |-> (vel_out != '0));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(note_on || note_off) |-> ($stable(key_out) && $stable(vel_out)));

   p_rt_transparent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_data[DATA_W-1 -: 5] == 5'b11111) |=> $stable(fsm_state));
endmodule

bind note_parser note_parser_chk #(.DATA_W(DATA_W), .N_ST(note_parser_pkg::NUM_ST)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_data   (rx_data),
   .rx_valid  (rx_valid),
   .note_on   (note_on),
   .note_off  (note_off),
   .key_out   (key_out),
   .vel_out   (vel_out),
   .fsm_state (fsm_state)
);

// File: tb/note_parser_test.sv
`timescale 1ns/1ps
module note_parser_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_valid = 1'b0;
   logic       note_on, note_off;
   logic [6:0] key_out, vel_out;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   // reference model state: 0 idle, 1 discard, 2 key, 3 velocity
   int         m_st  = 0;
   bit         m_on  = 1'b0;
   logic [6:0] m_pk  = '0;
   logic [6:0] m_key = '0;
   logic [6:0] m_vel = '0;

   always #2 clk = ~clk;

   note_parser uut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .note_on(note_on), .note_off(note_off), .key_out(key_out), .vel_out(vel_out)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic bit is_rt(input logic [7:0] b);
      return b >= 8'hF8;
   endfunction

   task automatic check_outs(input string tag, input bit eon, input bit eoff);
      chk(tag, "note_on",  int'(note_on),  int'(eon));
      chk(tag, "note_off", int'(note_off), int'(eoff));
      chk(tag, "key_out",  int'(key_out),  int'(m_key));
      chk(tag, "vel_out",  int'(vel_out),  int'(m_vel));
   endtask

   task automatic send(input logic [7:0] b, input string tag);
      bit eon = 1'b0;
      bit eoff = 1'b0;
      if (is_rt(b)) begin
      end else if (b[7:4] == 4'h9 || b[7:4] == 4'h8) begin
         m_st = 2;
         m_on = (b[7:4] == 4'h9);
      end else if (b[7]) begin
         m_st = 1;
      end else if (m_st == 2) begin
         m_pk = b[6:0];
         m_st = 3;
      end else if (m_st == 3) begin
         m_key = m_pk;
         m_vel = b[6:0];
         if (m_on && b[6:0] != 7'd0) eon = 1'b1;
         else                        eoff = 1'b1;
         m_st = 2;
      end
      @(negedge clk);
      rx_data  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      check_outs(tag, eon, eoff);
   endtask

   task automatic idle_junk(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_data  = (i % 2 == 0) ? 8'h93 : 8'h00;
         rx_valid = 1'b0;
         @(negedge clk);
         check_outs(tag, 1'b0, 1'b0);
      end
   endtask

   function automatic logic [7:0] rand_byte();
      int r = $urandom % 16;
      if (r < 3)       return 8'h90 | 8'($urandom % 16);
      else if (r == 3) return 8'h80 | 8'($urandom % 16);
      else if (r == 4) return 8'hF8 + 8'($urandom % 8);
      else if (r == 5) return 8'hA0 + 8'($urandom % 88);
      else if (r == 6) return 8'h00;
      else             return 8'($urandom % 128);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20461));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R11", 1'b0, 1'b0);            // reset state
      send(8'h3C, "R11");                       // leading data dropped
      send(8'h40, "R11");
      send(8'h95, "R2");                        // note-on, channel 5
      send(8'h3C, "R2");
      send(8'h64, "R3");
      send(8'h8F, "R4");                        // note-off, channel 15
      send(8'h3C, "R4");
      send(8'h7F, "R4");
      send(8'h90, "R5");                        // zero-velocity note-on
      send(8'h45, "R5");
      send(8'h00, "R5");
      send(8'h47, "R7");                        // running status pairs
      send(8'h20, "R7");
      send(8'h48, "R7");
      send(8'h00, "R7");
      send(8'h30, "R1");                        // gap with junk on the bus
      idle_junk(4, "R1");
      send(8'h11, "R1");
      send(8'h91, "R8");                        // real-time inside a message
      send(8'hF8, "R8");
      send(8'h50, "R8");
      send(8'hFE, "R8");
      send(8'hFF, "R8");
      send(8'h22, "R8");
      send(8'hB0, "R9");                        // foreign status: discard
      send(8'h07, "R9");
      send(8'h64, "R9");
      send(8'h33, "R9");
      send(8'h92, "R9");
      send(8'h52, "R9");
      send(8'h53, "R9");
      send(8'h93, "R10");                       // abandon partial (also walks R12 states)
      send(8'h60, "R10");
      send(8'h83, "R10");
      send(8'h61, "R10");
      send(8'h70, "R10");
      send(8'hF0, "R12");
      send(8'h90, "R12");
      send(8'h01, "R6");
      send(8'h02, "R6");
      for (int i = 0; i < 3000; i++) send(rand_byte(), "R7");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule